// File: doc/BRIEF.md
# Gated-Entry Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word so that a controller can drive a bank of LEDs or similar loads from a few pins. The bit that enters the first stage is the AND of two serial data inputs. Either input can therefore act as a data line while the other acts as an enable, and holding either one low forces zeros into the register. On every rising clock edge, each stage passes its bit one place toward the last stage. The bit that was in the last stage is dropped.

An active-low clear empties every stage at once, without waiting for a clock. Release of the clear is synchronised inside the block, so the first two rising edges after release do not shift. An active-high output enable forces the parallel word to zero while a new pattern is being loaded. The stages keep shifting behind that gate. A serial output carries the last stage, ungated, for cascading several blocks. A parameter can tie this output to zero.

Top module: `gated_shift_reg`

## Requirements
- R1: On each shifting edge, stage 0 (`par_o[0]`) loads `ser_a_i & ser_b_i`: 1 only when both are high, 0 when either is low.
- R2: On each shifting edge, stage i (i ≥ 1) loads the value that stage i-1 held before that edge.
- R3: The last stage's value leaves the register at each shift and is never fed back. After WIDTH shifts of zeros, every stage is 0.
- R4: While `rst_ni` is low, `par_o` and `ser_o` are 0 immediately, with no clock edge needed.
- R5: Rising clock edges that occur while `rst_ni` is low leave all stages at 0, whatever the serial inputs are.
- R6: After `rst_ni` goes high, the first SYNC_STAGES (default 2) rising edges do not shift. The next edge is the first shift.
- R7: Between rising edges, the stages hold their values however often `ser_a_i` and `ser_b_i` change.
- R8: While `out_en_i` is 0, `par_o` is all zeros and the stages keep shifting. When `out_en_i` returns to 1, `par_o` shows the current stage contents.
- R9: With HAS_SER_OUT=1 (default), `ser_o` equals the last stage (bit WIDTH-1) regardless of `out_en_i`. With HAS_SER_OUT=0 it is constant 0.
- R10: A WIDTH-bit word fed in MSB first, one bit per shifting edge, appears on `par_o` as that same word after WIDTH shifts, with its MSB at `par_o[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; shifting happens on the rising edge |
| rst_ni | input | 1 | Active-low clear; asserts asynchronously, releases synchronously |
| ser_a_i | input | 1 | Serial data input, ANDed with `ser_b_i` |
| ser_b_i | input | 1 | Serial data input, ANDed with `ser_a_i` |
| out_en_i | input | 1 | Active-high gate on the parallel outputs |
| par_o | output | WIDTH | Gated stage contents; bit 0 is the entry stage |
| ser_o | output | 1 | Last stage, ungated, for cascading |

## Verification
The bench drives all four serial input combinations. A design that ORs the inputs, or ignores one of them, loads the wrong entry bit. The bench feeds an MSB-first word and then a run of zeros. A reversed bit order shows up as a mirrored word, and any recirculation leaves ones behind. The bench pulses clear between clock edges and holds it across edges with both inputs high. It then counts the idle edges after release. A synchronous clear, a clear that a clock edge overrides, or a release that shifts too early all give mismatches. The bench also toggles the inputs between edges and closes the output gate during shifting. A level-sensitive capture, or a gate that stops the stages, diverges from the queue model.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  parameter int unsigned GSR_DEF_WIDTH = 8;
  parameter int unsigned GSR_DEF_SYNC  = 2;
endpackage

// File: rtl/gsr_clr_sync.sv
module gsr_clr_sync #(
  parameter int unsigned STAGES = gsr_pkg::GSR_DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clr_no
);
  logic [STAGES-1:0] sync_q;

  // assert at once, release after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign clr_no = sync_q[STAGES-1];
endmodule

// File: rtl/gsr_chain.sv
module gsr_chain #(
  parameter int unsigned WIDTH = gsr_pkg::GSR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             din_i,
  output logic [WIDTH-1:0] stage_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = din_i;
    end else begin : g_body
      assign d = stage_o[i-1];
    end
    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) stage_o[i] <= 1'b0;
      else         stage_o[i] <= d;
    end
  end
endmodule

// File: rtl/gsr_out_gate.sv
module gsr_out_gate #(
  parameter int unsigned WIDTH       = gsr_pkg::GSR_DEF_WIDTH,
  parameter bit          HAS_SER_OUT = 1'b1
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] stage_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  assign par_o = stage_i & {WIDTH{en_i}};

  if (HAS_SER_OUT) begin : g_ser
    assign ser_o = stage_i[WIDTH-1];
  end else begin : g_no_ser
    assign ser_o = 1'b0;
  end
endmodule

// File: rtl/gated_shift_reg.sv
module gated_shift_reg #(
  parameter int unsigned WIDTH       = gsr_pkg::GSR_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = gsr_pkg::GSR_DEF_SYNC,
  parameter bit          HAS_SER_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_a_i,
  input  logic             ser_b_i,
  input  logic             out_en_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  logic             clr_n;
  logic             entry_bit;
  logic [WIDTH-1:0] stage_q;

  assign entry_bit = ser_a_i & ser_b_i;

  gsr_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_no (clr_n)
  );

  gsr_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .din_i   (entry_bit),
    .stage_o (stage_q)
  );

  gsr_out_gate #(.WIDTH(WIDTH), .HAS_SER_OUT(HAS_SER_OUT)) u_gate (
    .en_i    (out_en_i),
    .stage_i (stage_q),
    .par_o   (par_o),
    .ser_o   (ser_o)
  );
endmodule

// File: rtl/gsr_checker.sv
module gsr_checker #(
  parameter int unsigned WIDTH = gsr_pkg::GSR_DEF_WIDTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_a_i,
  input logic             ser_b_i,
  input logic             run_i,
  input logic [WIDTH-1:0] stage_i,
  input logic [WIDTH-1:0] par_o,
  input logic             ser_o
);
  assert_entry_and_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> stage_i[0] == $past(ser_a_i & ser_b_i));

  assert_shift_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> stage_i[WIDTH-1:1] == $past(stage_i[WIDTH-2:0]));

  assert_release_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> stage_i == '0);

  // R4: outputs empty while clear is low
  always @(negedge clk_i) begin
    if (rst_ni === 1'b0) begin
      assert_clear_empty_R4: assert (par_o == '0 && ser_o == 1'b0);
    end
  end
endmodule

bind gated_shift_reg gsr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ser_a_i (ser_a_i),
  .ser_b_i (ser_b_i),
  .run_i   (clr_n),
  .stage_i (stage_q),
  .par_o   (par_o),
  .ser_o   (ser_o)
);

// File: tb/gated_shift_reg_tb_top.sv
module gated_shift_reg_tb_top;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_a_i = 1'b0, ser_b_i = 1'b0, out_en_i = 1'b1;
  logic [W-1:0] par_o;
  logic ser_o;

  int n_chk = 0, n_fail = 0;
  bit mq[$];
  int hold_cnt = 0;

  always #10 clk_i = ~clk_i;

  gated_shift_reg #(.WIDTH(W), .SYNC_STAGES(SYNC), .HAS_SER_OUT(1'b1)) dut_i (
    .clk_i, .rst_ni, .ser_a_i, .ser_b_i, .out_en_i, .par_o, .ser_o
  );

  function automatic logic [W-1:0] model_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = mq[i];
    return v;
  endfunction

  task automatic model_clear();
    mq.delete();
    for (int i = 0; i < W; i++) mq.push_back(1'b0);
  endtask

  task automatic compare(string tag);
    logic [W-1:0] exp_par;
    logic exp_ser;
    exp_par = (rst_ni && out_en_i) ? model_vec() : '0;
    exp_ser = rst_ni ? mq[W-1] : 1'b0;
    n_chk++;
    if (par_o !== exp_par) begin
      n_fail++;
      $display("FAIL %s par_o actual=%b expected=%b", tag, par_o, exp_par);
    end
    n_chk++;
    if (ser_o !== exp_ser) begin
      n_fail++;
      $display("FAIL %s ser_o actual=%b expected=%b", tag, ser_o, exp_ser);
    end
  endtask

  // drive after a negedge, model the edge, compare at the next negedge
  task automatic tick(logic a, logic b, string tag);
    ser_a_i = a; ser_b_i = b;
    @(posedge clk_i);
    if (!rst_ni) model_clear();
    else if (hold_cnt > 0) hold_cnt--;
    else begin
      mq.push_front(a & b);
      void'(mq.pop_back());
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic release_clear();
    rst_ni = 1'b1;
    hold_cnt = SYNC;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    logic [W-1:0] snap;
    model_clear();
    @(negedge clk_i);
    compare("R4 reset state");
    @(negedge clk_i);
    release_clear();
    // R6: two idle edges with both inputs high
    tick(1, 1, "R6 release edge 1");
    tick(1, 1, "R6 release edge 2");
    // R1: all four input combinations
    tick(1, 1, "R1 a=1 b=1");
    tick(0, 1, "R1 a=0 b=1");
    tick(1, 0, "R1 a=1 b=0");
    tick(0, 0, "R1 a=0 b=0");
    tick(1, 1, "R1 a=1 b=1 again");
    // R2/R10: MSB-first word
    pat = 8'b1011_0010;
    for (int k = W - 1; k >= 0; k--) tick(pat[k], 1'b1, "R2 shift word");
    n_chk++;
    if (par_o !== pat) begin
      n_fail++;
      $display("FAIL R10 par_o actual=%b expected=%b", par_o, pat);
    end
    // R7: inputs wiggle between edges
    snap = par_o;
    for (int k = 0; k < 6; k++) begin
      ser_a_i = k[0]; ser_b_i = ~k[1];
      #1;
    end
    n_chk++;
    if (par_o !== snap) begin
      n_fail++;
      $display("FAIL R7 par_o actual=%b expected=%b", par_o, snap);
    end
    // R8/R9: gate closed while shifting, serial out ungated
    out_en_i = 1'b0;
    tick(1, 1, "R8 gated shift 1");
    tick(0, 1, "R9 gated shift 2");
    tick(1, 1, "R8 gated shift 3");
    out_en_i = 1'b1;
    #1;
    compare("R8 gate reopened");
    // R3: flush with zeros
    for (int k = 0; k < W; k++) tick(0, 0, "R3 flush");
    n_chk++;
    if (par_o !== '0) begin
      n_fail++;
      $display("FAIL R3 par_o actual=%b expected=%b", par_o, {W{1'b0}});
    end
    // R4/R5: clear in the middle of a shift
    for (int k = 0; k < 4; k++) tick(1, 1, "R2 refill");
    #3;
    rst_ni = 1'b0;
    model_clear();
    #1;
    compare("R4 async clear");
    @(negedge clk_i);
    tick(1, 1, "R5 edge under clear");
    tick(1, 1, "R5 second edge under clear");
    release_clear();
    tick(1, 1, "R6 post-clear edge 1");
    tick(1, 1, "R6 post-clear edge 2");
    tick(1, 1, "R6 first shift");
    tick(1, 0, "R1 post-clear zero");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule